// File: doc/BRIEF.md
# Debounced Battery Swap Detector

This block sits beside a fuel-gauge core and decides when a battery has really been pulled out or the supply has really collapsed. It watches two comparator outputs: one that goes high when the pack looks absent, and one that goes high when the supply falls below the lockout level. Each is timed against a half-second persistence filter clocked by a 32768 Hz tick enable. Short bounces on the battery contacts or brief supply dips leave no trace and do not interrupt operation. A qualified event sets a sticky status flag and raises a hold output that freezes the gauge until software writes the self-clearing soft-reset bit.

The block also drives the charge-inhibit output during the measurement window that follows power-up or a soft reset. The inhibit decision is taken once, at the start of that window, from the battery-present and supply-above-minimum comparators. The window ends when the gauge signals that its first measurement is done. A software force bit asserts charge inhibit at any time.

Top module: `swapdet_top`

## Requirements
- R1: `fail_flag` is set on the tick edge that completes FILT_TICKS consecutive ticks with `absent_cmp` high (16384 ticks, 0.5 s at 32768 Hz, by default).
- R2: `uv_flag` is set on the tick edge that completes FILT_TICKS consecutive ticks with `uvlo_cmp` high, and a flag write with bit 1 of `flag_wr_data` at 0 clears it.
- R3: A run of high input shorter than FILT_TICKS ticks sets no flag and raises no hold; a low input restarts the count from zero.
- R4: A flag write with bit 0 of `flag_wr_data` at 0 clears `fail_flag` only while `absent_cmp` is low; a written 1 in either bit changes nothing.
- R5: A qualified event on either input raises `hold`; both flags stay set until cleared by software, even after the inputs return to normal.
- R6: `hold` falls only on a `soft_rst_req` strobe, which also clears both flags and both filter counts in the same edge; no other input releases it.
- R7: One edge after reset release or after a `soft_rst_req` strobe, `restart_busy` rises and `chg_inhibit` goes high only if, at that edge, `absent_cmp` was low and `vin_ok_cmp` was high; later changes of those inputs do not alter the decision.
- R8: `force_inhibit` high drives `chg_inhibit` high in the same cycle, regardless of the window.
- R9: A `meas_done` pulse during the window ends it: `restart_busy` and the window part of `chg_inhibit` fall on that edge.
- R10: When a qualifying tick and a clearing flag write land in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| absent_cmp | input | 1 | High when the battery-detect pin is above its threshold (pack absent) |
| uvlo_cmp | input | 1 | High when the supply is below the lockout level |
| vin_ok_cmp | input | 1 | High when the battery voltage is above the charge-inhibit minimum |
| flag_wr_en | input | 1 | Status flag write strobe |
| flag_wr_data | input | 2 | Write data: bit 0 battery-fail flag, bit 1 undervoltage flag |
| soft_rst_req | input | 1 | Strobe of the self-clearing soft-reset bit |
| force_inhibit | input | 1 | Software force of charge inhibit |
| meas_done | input | 1 | Pulse from the gauge when the initial measurement is complete |
| fail_flag | output | 1 | Sticky battery-fail flag |
| uv_flag | output | 1 | Sticky undervoltage-event flag |
| hold | output | 1 | Gauge hold after a qualified swap event |
| chg_inhibit | output | 1 | Charge-inhibit output |
| restart_busy | output | 1 | High while the restart measurement window is open |

## Verification
The filter's qualifying tick and a software write that clears the same flag can fall in one cycle. The bench counts an input up to one tick short of the limit, then issues the final tick together with a clearing write, and judges that the flag reads set afterwards. It also sets the battery-fail flag and writes 0 while the absence input is still high, then again after it drops, to tell the gated clear apart from an unconditional one. The restart decision is probed by changing the comparators after the window has opened and checking that charge inhibit keeps its sampled value.

// File: rtl/swapdet_pkg.sv
package swapdet_pkg;

  localparam int unsigned SD_CHANNELS = 2;
  localparam int unsigned SD_CH_FAIL  = 0;
  localparam int unsigned SD_CH_UV    = 1;

  // Next value of a persistence counter that saturates at its limit.
  function automatic int unsigned sd_bump(input int unsigned cnt,
                                          input logic        step,
                                          input int unsigned limit);
    if (step && cnt < limit) return cnt + 1;
    return cnt;
  endfunction

  // Charging may be held off only for a present pack above the minimum.
  function automatic logic sd_charge_ok(input logic absent,
                                        input logic vin_ok);
    return !absent && vin_ok;
  endfunction

endpackage

// File: rtl/swapdet_persist.sv
module swapdet_persist #(
  parameter int unsigned FILT_TICKS = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic din,
  output logic fire
);
  import swapdet_pkg::*;

  localparam int unsigned CW = $clog2(FILT_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign last_step = din && tick && (cnt_q == CW'(FILT_TICKS - 1));
  assign fire      = last_step && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || !din) cnt_q <= '0;
    else                  cnt_q <= CW'(sd_bump(int'(cnt_q), tick, FILT_TICKS));
  end

  // R3: a run of high input qualifies once, not on every following tick
  p_fire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R3: a qualifying event needs the input to have been high a cycle before too
  p_fire_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && FILT_TICKS > 1) |-> $past(din));

endmodule

// File: rtl/swapdet_restart.sv
module swapdet_restart (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic absent,
  input  logic vin_ok,
  input  logic meas_done,
  input  logic force_inh,
  output logic busy,
  output logic chg_inhibit
);
  import swapdet_pkg::*;

  logic start_q;
  logic win_q;
  logic ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      win_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      start_q <= start_req;
      if (start_q) begin
        win_q <= 1'b1;
        ok_q  <= sd_charge_ok(absent, vin_ok);
      end else if (win_q && meas_done) begin
        win_q <= 1'b0;
      end
    end
  end

  assign busy        = win_q;
  assign chg_inhibit = force_inh || (win_q && ok_q);

  // R8: the force bit overrides everything in the same cycle
  p_force_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_inh |-> chg_inhibit);

  // R7: without the force bit, inhibit only appears inside the window
  p_inhibit_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_inhibit && !force_inh) |-> busy);

  // R9: the window only closes on a done pulse
  p_window_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(meas_done));

endmodule

// File: rtl/swapdet_top.sv
module swapdet_top #(
  parameter int unsigned FILT_TICKS = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       absent_cmp,
  input  logic       uvlo_cmp,
  input  logic       vin_ok_cmp,
  input  logic       flag_wr_en,
  input  logic [1:0] flag_wr_data,
  input  logic       soft_rst_req,
  input  logic       force_inhibit,
  input  logic       meas_done,
  output logic       fail_flag,
  output logic       uv_flag,
  output logic       hold,
  output logic       chg_inhibit,
  output logic       restart_busy
);
  import swapdet_pkg::*;

  logic [SD_CHANNELS-1:0] chan_in;
  logic [SD_CHANNELS-1:0] chan_fire;
  logic                   fail_clr_ok;
  logic                   uv_clr_ok;

  assign chan_in[SD_CH_FAIL] = absent_cmp;
  assign chan_in[SD_CH_UV]   = uvlo_cmp;

  for (genvar g = 0; g < SD_CHANNELS; g++) begin : g_filt
    swapdet_persist #(.FILT_TICKS(FILT_TICKS)) filt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (soft_rst_req),
      .tick (tick),
      .din  (chan_in[g]),
      .fire (chan_fire[g])
    );
  end

  assign fail_clr_ok = flag_wr_en && !flag_wr_data[SD_CH_FAIL] && !absent_cmp;
  assign uv_clr_ok   = flag_wr_en && !flag_wr_data[SD_CH_UV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flag <= 1'b0;
      uv_flag   <= 1'b0;
      hold      <= 1'b0;
    end else if (soft_rst_req) begin
      fail_flag <= 1'b0;
      uv_flag   <= 1'b0;
      hold      <= 1'b0;
    end else begin
      if (chan_fire[SD_CH_FAIL])  fail_flag <= 1'b1;
      else if (fail_clr_ok)       fail_flag <= 1'b0;
      if (chan_fire[SD_CH_UV])    uv_flag   <= 1'b1;
      else if (uv_clr_ok)         uv_flag   <= 1'b0;
      if (|chan_fire)             hold      <= 1'b1;
    end
  end

  swapdet_restart restart_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (soft_rst_req),
    .absent     (absent_cmp),
    .vin_ok     (vin_ok_cmp),
    .meas_done  (meas_done),
    .force_inh  (force_inhibit),
    .busy       (restart_busy),
    .chg_inhibit(chg_inhibit)
  );

  // R1: the battery-fail flag only rises after the absence input was high
  p_fail_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(absent_cmp));

  // R2: the undervoltage flag only rises after the lockout input was high
  p_uv_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flag) |-> $past(uvlo_cmp));

  // R4: the battery-fail flag never clears while the pack still looks absent
  p_fail_clear_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> ($past(soft_rst_req) || !$past(absent_cmp)));

  // R6: hold is released by the soft-reset strobe alone
  p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(soft_rst_req));

  // R5: any flag rising comes with hold
  p_hold_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fail_flag) || $rose(uv_flag)) |-> hold);

endmodule

// File: tb/swapdet_top_tb_top.sv
module swapdet_top_tb_top;

  localparam int unsigned NT = 16;

  typedef struct {
    int    sig;
    logic  exp;
    string req;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       absent_cmp = 1'b0;
  logic       uvlo_cmp = 1'b0;
  logic       vin_ok_cmp = 1'b1;
  logic       flag_wr_en = 1'b0;
  logic [1:0] flag_wr_data = 2'b11;
  logic       soft_rst_req = 1'b0;
  logic       force_inhibit = 1'b0;
  logic       meas_done = 1'b0;
  logic       fail_flag, uv_flag, hold, chg_inhibit, restart_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  exp_item_t sb_q[$];

  always #2.5 clk = ~clk;

  swapdet_top #(.FILT_TICKS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .absent_cmp(absent_cmp), .uvlo_cmp(uvlo_cmp), .vin_ok_cmp(vin_ok_cmp),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .soft_rst_req(soft_rst_req), .force_inhibit(force_inhibit),
    .meas_done(meas_done),
    .fail_flag(fail_flag), .uv_flag(uv_flag), .hold(hold),
    .chg_inhibit(chg_inhibit), .restart_busy(restart_busy)
  );

  function automatic logic pick(input int s);
    case (s)
      0: return fail_flag;
      1: return uv_flag;
      2: return hold;
      3: return chg_inhibit;
      default: return restart_busy;
    endcase
  endfunction

  function automatic string sname(input int s);
    case (s)
      0: return "fail_flag";
      1: return "uv_flag";
      2: return "hold";
      3: return "chg_inhibit";
      default: return "restart_busy";
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (pick(it.sig) !== it.exp) begin
        errors++;
        $display("FAIL %s %s actual=%b expected=%b", it.req, sname(it.sig),
                 pick(it.sig), it.exp);
      end
    end
  end

  task automatic expect_sig(input int s, input logic e, input string r);
    sb_q.push_back('{s, e, r});
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one tick edge followed by an idle cycle; optional write on the tick cycle
  task automatic tick_once(input logic wr, input logic [1:0] wd);
    tick = 1'b1; flag_wr_en = wr; flag_wr_data = wd;
    step();
    tick = 1'b0; flag_wr_en = 1'b0; flag_wr_data = 2'b11;
    step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_once(1'b0, 2'b11);
  endtask

  task automatic write_flags(input logic [1:0] wd);
    flag_wr_en = 1'b1; flag_wr_data = wd;
    step();
    flag_wr_en = 1'b0; flag_wr_data = 2'b11;
  endtask

  task automatic soft_reset();
    soft_rst_req = 1'b1;
    step();
    soft_rst_req = 1'b0;
  endtask

  task automatic done_pulse();
    meas_done = 1'b1;
    step();
    meas_done = 1'b0;
  endtask

  task automatic settle();
    step();
  endtask

  initial begin
    #1;
    // reset state
    expect_sig(0, 1'b0, "R1 reset"); expect_sig(1, 1'b0, "R2 reset");
    expect_sig(2, 1'b0, "R5 reset"); expect_sig(4, 1'b0, "R7 reset");
    step(); step();
    rst_n = 1'b1;
    step();
    // power-up window opened with present pack and good voltage
    expect_sig(4, 1'b1, "R7 power-up window"); expect_sig(3, 1'b1, "R7 power-up inhibit");
    step();
    done_pulse();
    expect_sig(4, 1'b0, "R9 window end"); expect_sig(3, 1'b0, "R9 inhibit release");
    settle();

    // R3: short run, then interrupted runs
    absent_cmp = 1'b1; uvlo_cmp = 1'b1;
    ticks(NT - 1);
    absent_cmp = 1'b0; uvlo_cmp = 1'b0;
    step();
    expect_sig(0, 1'b0, "R3 short absence"); expect_sig(1, 1'b0, "R3 short dip");
    expect_sig(2, 1'b0, "R3 no hold");
    absent_cmp = 1'b1;
    ticks(NT - 1);
    absent_cmp = 1'b0; step();
    absent_cmp = 1'b1;
    ticks(NT - 1);
    expect_sig(0, 1'b0, "R3 dropout restarts count");
    settle();

    // R1/R5: full run qualifies
    absent_cmp = 1'b0; step();
    absent_cmp = 1'b1;
    ticks(NT - 1);
    expect_sig(0, 1'b0, "R1 one tick short");
    settle();
    ticks(1);
    expect_sig(0, 1'b1, "R1 qualified"); expect_sig(2, 1'b1, "R5 hold raised");
    expect_sig(1, 1'b0, "R2 untouched");
    settle();

    // R4: clear blocked while absent; writing 1 ignored
    write_flags(2'b10);
    expect_sig(0, 1'b1, "R4 clear blocked while absent");
    settle();
    absent_cmp = 1'b0; step();
    write_flags(2'b11);
    expect_sig(0, 1'b1, "R4 write of one ignored");
    expect_sig(0, 1'b1, "R5 sticky after input normal");
    settle();
    write_flags(2'b10);
    expect_sig(0, 1'b0, "R4 clear while present");
    expect_sig(2, 1'b1, "R6 hold survives flag clear");
    settle();

    // R2: undervoltage flag set and cleared
    uvlo_cmp = 1'b1;
    ticks(NT);
    expect_sig(1, 1'b1, "R2 undervoltage qualified");
    settle();
    uvlo_cmp = 1'b0; step();
    write_flags(2'b01);
    expect_sig(1, 1'b0, "R2 clear by zero");
    settle();

    // R10: qualifying tick and clear in the same cycle
    uvlo_cmp = 1'b1;
    ticks(NT - 1);
    tick_once(1'b1, 2'b01);
    expect_sig(1, 1'b1, "R10 set wins over clear");
    settle();
    uvlo_cmp = 1'b0; step();

    // R6: done pulse does not release hold; soft reset does
    done_pulse();
    expect_sig(2, 1'b1, "R6 done does not release hold");
    settle();
    absent_cmp = 1'b1;      // pack absent at restart start
    soft_reset();
    expect_sig(2, 1'b0, "R6 hold released"); expect_sig(1, 1'b0, "R6 flags cleared");
    settle();
    expect_sig(4, 1'b1, "R7 restart window open");
    expect_sig(3, 1'b0, "R7 absent pack no inhibit");
    absent_cmp = 1'b0;
    step();
    expect_sig(3, 1'b0, "R7 decision not resampled");
    done_pulse();
    expect_sig(4, 1'b0, "R9 window closed");
    settle();

    // R7: low voltage at start
    vin_ok_cmp = 1'b0;
    soft_reset(); step();
    expect_sig(3, 1'b0, "R7 low voltage no inhibit");
    vin_ok_cmp = 1'b1; step();
    done_pulse();
    // R7: good start, later voltage drop keeps inhibit
    soft_reset(); step();
    expect_sig(3, 1'b1, "R7 good start inhibit");
    vin_ok_cmp = 1'b0; step();
    expect_sig(3, 1'b1, "R7 inhibit held after drop");
    done_pulse();
    expect_sig(3, 1'b0, "R9 inhibit released");
    settle();
    vin_ok_cmp = 1'b1;

    // R8: force bit
    force_inhibit = 1'b1; #0.5;
    expect_sig(3, 1'b1, "R8 force outside window");
    settle();
    force_inhibit = 1'b0; #0.5;
    expect_sig(3, 1'b0, "R8 force removed");
    settle(); step();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule